// File: doc/BRIEF.md
# Precise Exception Tracking Pipeline

This block is the exception bookkeeping spine of a five-stage in-order core: fetch, decode with operand read, execute, memory access and writeback. Each instruction carries a small status record (valid bit, PC, 3-bit cause) through the stages. Any of the first four stages may flag a fault against the instruction it currently holds. The fault is stored in that instruction's record. It is only acted on when the record reaches writeback, so traps are always taken in program order.

The surrounding core supplies a fetch-valid strobe, per-stage fault strobes and two stall controls. The block keeps the fetch PC itself. At writeback it either retires the instruction, which enables the register-file write, or raises a trap. A trap flushes every younger stage, latches the faulting PC and cause, and redirects fetch to a fixed handler address. While the instruction is in the memory stage, a memory-access enable tells the memory port whether it may act. Real memory, decode and arithmetic logic sit outside and appear here only as fault strobes.

Top module: `precise_trap_pipe`

## Requirements
- R1: While reset is held, trap_o and rf_we_o are 0, mem_acc_en_o is 0, fetch_pc_o equals RESET_PC (default 0x100), and trap_pc_o and trap_cause_o are 0.
- R2: An instruction accepted with fetch_valid_i is stamped with fetch_pc_o, and fetch_pc_o then advances by 4. With no stalls or faults it appears in writeback 5 clock edges later, with rf_we_o=1 and retire_pc_o set to its PC.
- R3: Fetch-stage strobes if_flt_i bit0 (instruction page fault), bit1 (misaligned) and bit2 (protection) give causes 1, 2 and 3. When several bits are set, the lowest-numbered bit wins.
- R4: id_flt_i gives cause 4 (illegal opcode) and ex_flt_i gives cause 5 (arithmetic). mem_flt_i bit0 (data page fault) gives cause 6 and has priority. mem_flt_i bit1 (misaligned) or bit2 (protection) gives cause 7.
- R5: trap_o is high during the cycle a faulting instruction is in writeback. At that edge trap_pc_o and trap_cause_o take its PC and cause, and they hold those values until the next trap.
- R6: Traps are taken in program order. An older instruction's fault wins over a younger instruction's fault, whether the younger fault was flagged in the same cycle or earlier.
- R7: An instruction keeps the first cause recorded for it. Strobes in later stages, or in later cycles while it is stalled, are ignored.
- R8: A faulted instruction never raises rf_we_o, and mem_acc_en_o is 0 while it sits in the memory stage.
- R9: In the trap cycle flush_o is 4'b1111, with bit0=fetch through bit3=memory. No instruction that was in flight retires afterwards: rf_we_o stays 0 for the next 5 cycles.
- R10: After a trap, fetch_pc_o equals HANDLER_PC (default 0x80), and the next retired instruction has that PC.
- R11: id_stall_i holds the fetch and decode stages and fetch_pc_o, inserts an empty slot into execute, and lets execute, memory and writeback advance. A held instruction keeps its record and can still be faulted in place.
- R12: mem_stall_i holds fetch through memory and fetch_pc_o, and writeback receives an empty slot (rf_we_o=0 and trap_o=0 in the following cycle).
- R13: Fault strobes aimed at an empty stage are ignored: no trap results and later instructions are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | An instruction is fetched at fetch_pc_o this cycle |
| id_stall_i | input | 1 | Hold fetch and decode, bubble into execute |
| mem_stall_i | input | 1 | Hold fetch to memory, bubble into writeback |
| if_flt_i | input | 3 | Fetch-stage faults {protection, misaligned, page} |
| id_flt_i | input | 1 | Decode-stage illegal opcode |
| ex_flt_i | input | 1 | Execute-stage arithmetic fault |
| mem_flt_i | input | 3 | Memory-stage faults {protection, misaligned, page} |
| fetch_pc_o | output | 32 | Address of the next fetch |
| mem_acc_en_o | output | 1 | Memory-stage instruction may access memory |
| rf_we_o | output | 1 | Writeback instruction retires and writes registers |
| retire_pc_o | output | 32 | PC of the retiring instruction |
| trap_o | output | 1 | Trap taken this cycle |
| trap_pc_o | output | 32 | Latched PC of the last trapped instruction |
| trap_cause_o | output | 3 | Latched cause of the last trap |
| flush_o | output | 4 | Per-stage flush, bit0 fetch to bit3 memory |

## Verification
A behavioural reference model runs beside the design and is compared every cycle. It is driven with a continuous instruction stream plus fault injection in each stage on its own, so each cause encoding and its priority are isolated. Paired injections then separate program-order resolution from detection order: an older instruction in a later stage against a younger one in an earlier stage, in the same cycle and in staggered cycles. Repeated strobes on one instruction show that the first cause sticks. Decode and memory stalls with faults raised during the hold show that records stay with their instructions. Strobes into an empty pipeline just after a trap show that bubbles stay clean and that the handler instruction retires intact.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  parameter int unsigned PC_W    = 32;
  parameter int unsigned N_STAGE = 5;
  parameter int unsigned FLT_W   = 3;

  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_EX  = 2;
  localparam int ST_MEM = 3;
  localparam int ST_WB  = 4;

  typedef enum logic [2:0] {
    C_NONE  = 3'd0,
    C_IPF   = 3'd1,
    C_IMIS  = 3'd2,
    C_IPROT = 3'd3,
    C_ILL   = 3'd4,
    C_ARITH = 3'd5,
    C_DPF   = 3'd6,
    C_DACC  = 3'd7
  } cause_e;

  typedef struct packed {
    logic            valid;
    logic [PC_W-1:0] pc;
    cause_e          cause;
  } stage_t;
endpackage

// File: rtl/ptp_cause_enc.sv
module ptp_cause_enc
  import ptp_pkg::*;
#(
  parameter int STAGE = ST_IF
) (
  input  logic [FLT_W-1:0] flt_i,
  output cause_e           cause_o
);
  generate
    if (STAGE == ST_IF) begin : g_if
      assign cause_o = flt_i[0] ? C_IPF  :
                       flt_i[1] ? C_IMIS :
                       flt_i[2] ? C_IPROT : C_NONE;
    end else if (STAGE == ST_ID) begin : g_id
      assign cause_o = (|flt_i) ? C_ILL : C_NONE;
    end else if (STAGE == ST_EX) begin : g_ex
      assign cause_o = (|flt_i) ? C_ARITH : C_NONE;
    end else begin : g_mem
      // page fault outranks the access-rule faults
      assign cause_o = flt_i[0]      ? C_DPF  :
                       (|flt_i[2:1]) ? C_DACC : C_NONE;
    end
  endgenerate
endmodule

// File: rtl/ptp_stage.sv
module ptp_stage
  import ptp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  stage_t in_i,
  input  cause_e new_cause_i,
  input  logic   hold_i,
  input  logic   bubble_i,
  input  logic   flush_i,
  output stage_t out_o
);
  stage_t q;
  stage_t eff;

  // first cause sticks; empty slots never pick one up
  always_comb begin
    eff = q;
    if (q.valid && q.cause == C_NONE) eff.cause = new_cause_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (flush_i)  q <= '0;
    else if (hold_i)   q <= eff;
    else if (bubble_i) q <= '0;
    else               q <= in_i;
  end

  assign out_o = eff;
endmodule

// File: rtl/ptp_fetch.sv
module ptp_fetch
  import ptp_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_0100,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080,
  parameter logic [PC_W-1:0] PC_STEP    = 32'd4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            redirect_i,
  input  logic            adv_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_o <= RESET_PC;
    else if (redirect_i) pc_o <= HANDLER_PC;
    else if (adv_i)      pc_o <= pc_o + PC_STEP;
  end
endmodule

// File: rtl/ptp_commit.sv
module ptp_commit
  import ptp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  stage_t          wb_i,
  output logic            trap_o,
  output logic            retire_o,
  output logic [PC_W-1:0] retire_pc_o,
  output logic [PC_W-1:0] epc_o,
  output cause_e          ecause_o
);
  assign trap_o      = wb_i.valid && (wb_i.cause != C_NONE);
  assign retire_o    = wb_i.valid && (wb_i.cause == C_NONE);
  assign retire_pc_o = wb_i.pc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o    <= '0;
      ecause_o <= C_NONE;
    end else if (trap_o) begin
      epc_o    <= wb_i.pc;
      ecause_o <= wb_i.cause;
    end
  end
endmodule

// File: rtl/precise_trap_pipe.sv
module precise_trap_pipe
  import ptp_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_0100,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080,
  parameter logic [PC_W-1:0] PC_STEP    = 32'd4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_valid_i,
  input  logic             id_stall_i,
  input  logic             mem_stall_i,
  input  logic [FLT_W-1:0] if_flt_i,
  input  logic             id_flt_i,
  input  logic             ex_flt_i,
  input  logic [FLT_W-1:0] mem_flt_i,
  output logic [PC_W-1:0]  fetch_pc_o,
  output logic             mem_acc_en_o,
  output logic             rf_we_o,
  output logic [PC_W-1:0]  retire_pc_o,
  output logic             trap_o,
  output logic [PC_W-1:0]  trap_pc_o,
  output logic [2:0]       trap_cause_o,
  output logic [ST_WB-1:0] flush_o
);
  localparam int N_FLT = N_STAGE - 1;

  stage_t           st_in   [N_STAGE];
  stage_t           st_out  [N_STAGE];
  cause_e           st_new  [N_STAGE];
  logic             st_hold [N_STAGE];
  logic             st_bub  [N_STAGE];
  logic [FLT_W-1:0] flt     [N_FLT];
  logic             trap;
  logic             fetch_adv;
  cause_e           ecause;

  assign flt[ST_IF]  = if_flt_i;
  assign flt[ST_ID]  = {{(FLT_W-1){1'b0}}, id_flt_i};
  assign flt[ST_EX]  = {{(FLT_W-1){1'b0}}, ex_flt_i};
  assign flt[ST_MEM] = mem_flt_i;

  assign fetch_adv = fetch_valid_i && !id_stall_i && !mem_stall_i;

  ptp_fetch #(
    .RESET_PC  (RESET_PC),
    .HANDLER_PC(HANDLER_PC),
    .PC_STEP   (PC_STEP)
  ) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .redirect_i(trap),
    .adv_i     (fetch_adv),
    .pc_o      (fetch_pc_o)
  );

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    if (s == ST_IF) begin : g_src
      assign st_in[s] = '{valid: fetch_valid_i, pc: fetch_pc_o, cause: C_NONE};
    end else begin : g_chain
      assign st_in[s] = st_out[s-1];
    end

    if (s < N_FLT) begin : g_enc
      ptp_cause_enc #(.STAGE(s)) u_enc (
        .flt_i  (flt[s]),
        .cause_o(st_new[s])
      );
    end else begin : g_noenc
      assign st_new[s] = C_NONE;
    end

    // memory stall freezes fetch..memory; decode stall freezes fetch..decode
    if (s == ST_WB) begin : g_wb_ctl
      assign st_hold[s] = 1'b0;
      assign st_bub[s]  = mem_stall_i;
    end else if (s == ST_EX) begin : g_ex_ctl
      assign st_hold[s] = mem_stall_i;
      assign st_bub[s]  = id_stall_i && !mem_stall_i;
    end else if (s < ST_EX) begin : g_up_ctl
      assign st_hold[s] = mem_stall_i || id_stall_i;
      assign st_bub[s]  = 1'b0;
    end else begin : g_mem_ctl
      assign st_hold[s] = mem_stall_i;
      assign st_bub[s]  = 1'b0;
    end

    ptp_stage u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_i       (st_in[s]),
      .new_cause_i(st_new[s]),
      .hold_i     (st_hold[s]),
      .bubble_i   (st_bub[s]),
      .flush_i    (trap),
      .out_o      (st_out[s])
    );
  end

  ptp_commit u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wb_i       (st_out[ST_WB]),
    .trap_o     (trap),
    .retire_o   (rf_we_o),
    .retire_pc_o(retire_pc_o),
    .epc_o      (trap_pc_o),
    .ecause_o   (ecause)
  );

  assign mem_acc_en_o = st_out[ST_MEM].valid && (st_out[ST_MEM].cause == C_NONE) && !trap;
  assign trap_o       = trap;
  assign trap_cause_o = ecause;
  assign flush_o      = {ST_WB{trap}};
endmodule

// File: rtl/ptp_chk.sv
module ptp_chk
  import ptp_pkg::*;
#(
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            id_stall_i,
  input logic            mem_stall_i,
  input logic [PC_W-1:0] fetch_pc_o,
  input logic            mem_acc_en_o,
  input logic            rf_we_o,
  input logic            trap_o,
  input logic [PC_W-1:0] trap_pc_o,
  input logic [2:0]      trap_cause_o
);
  // R5
  trap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |=> $stable(trap_pc_o) && $stable(trap_cause_o));

  // R5
  trap_cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> trap_cause_o != 3'd0);

  // R8
  fault_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !rf_we_o && !mem_acc_en_o);

  // R9
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !trap_o && !rf_we_o);

  // R10
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> fetch_pc_o == HANDLER_PC);

  // R11
  stall_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_stall_i || mem_stall_i) && !trap_o |=> $stable(fetch_pc_o));

  // R12
  mem_stall_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stall_i && !trap_o |=> !rf_we_o && !trap_o);
endmodule

bind precise_trap_pipe ptp_chk #(.HANDLER_PC(HANDLER_PC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .id_stall_i  (id_stall_i),
  .mem_stall_i (mem_stall_i),
  .fetch_pc_o  (fetch_pc_o),
  .mem_acc_en_o(mem_acc_en_o),
  .rf_we_o     (rf_we_o),
  .trap_o      (trap_o),
  .trap_pc_o   (trap_pc_o),
  .trap_cause_o(trap_cause_o)
);

// File: tb/precise_trap_pipe_test.sv
module precise_trap_pipe_test;
  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam logic [31:0] HND_PC = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fv = 0, ids = 0, ms = 0, fd = 0, fe = 0;
  logic [2:0]  fi = 0, fm = 0;
  logic [31:0] fetch_pc, retire_pc, trap_pc;
  logic        mem_acc, rf_we, trap;
  logic [2:0]  trap_cause;
  logic [3:0]  flush;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  precise_trap_pipe #(.RESET_PC(RST_PC), .HANDLER_PC(HND_PC), .PC_STEP(32'd4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_valid_i(fv), .id_stall_i(ids), .mem_stall_i(ms),
    .if_flt_i(fi), .id_flt_i(fd), .ex_flt_i(fe), .mem_flt_i(fm),
    .fetch_pc_o(fetch_pc), .mem_acc_en_o(mem_acc), .rf_we_o(rf_we), .retire_pc_o(retire_pc),
    .trap_o(trap), .trap_pc_o(trap_pc), .trap_cause_o(trap_cause), .flush_o(flush)
  );

  // reference model state: index 0=fetch .. 4=writeback
  int          mv[5], mc[5], ec[5];
  logic [31:0] mpc[5];
  logic [31:0] mfpc, mepc;
  int          mcause;
  bit          etrap;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int enc(input int s, input logic [2:0] f);
    case (s)
      0: return f[0] ? 1 : f[1] ? 2 : f[2] ? 3 : 0;
      1: return f[0] ? 4 : 0;
      2: return f[0] ? 5 : 0;
      default: return f[0] ? 6 : (f[1] | f[2]) ? 7 : 0;
    endcase
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 5; k++) begin mv[k] = 0; mc[k] = 0; ec[k] = 0; mpc[k] = 0; end
    mfpc = RST_PC; mepc = 0; mcause = 0; etrap = 0;
  endtask

  // apply inputs, then compare every output against the model
  task automatic drive(input logic v, input logic si, input logic sm, input logic [2:0] a,
                       input logic b, input logic c, input logic [2:0] d);
    fv = v; ids = si; ms = sm; fi = a; fd = b; fe = c; fm = d;
    #1;
    for (int k = 0; k < 5; k++) ec[k] = mc[k];
    if (mv[0] != 0 && mc[0] == 0) ec[0] = enc(0, fi);
    if (mv[1] != 0 && mc[1] == 0) ec[1] = enc(1, {2'b0, fd});
    if (mv[2] != 0 && mc[2] == 0) ec[2] = enc(2, {2'b0, fe});
    if (mv[3] != 0 && mc[3] == 0) ec[3] = enc(3, fm);
    etrap = (mv[4] != 0) && (mc[4] != 0);
    chk("R10 fetch_pc", fetch_pc, mfpc);
    chk("R5 trap", {31'b0, trap}, {31'b0, etrap});
    chk("R2 rf_we", {31'b0, rf_we}, {31'b0, (mv[4] != 0 && mc[4] == 0)});
    if (mv[4] != 0 && mc[4] == 0) chk("R2 retire_pc", retire_pc, mpc[4]);
    chk("R8 mem_acc", {31'b0, mem_acc}, {31'b0, (mv[3] != 0 && ec[3] == 0 && !etrap)});
    chk("R9 flush", {28'b0, flush}, etrap ? 32'hF : 32'h0);
    chk("R5 trap_pc", trap_pc, mepc);
    chk("R5 trap_cause", {29'b0, trap_cause}, mcause);
  endtask

  task automatic tick();
    int nv[5], nc[5];
    logic [31:0] npc[5];
    bit stl;
    @(posedge clk);
    stl = ms || ids;
    for (int k = 0; k < 5; k++) begin nv[k] = mv[k]; nc[k] = ec[k]; npc[k] = mpc[k]; end
    if (etrap) begin
      for (int k = 0; k < 5; k++) begin nv[k] = 0; nc[k] = 0; npc[k] = 0; end
      mepc = mpc[4]; mcause = mc[4]; mfpc = HND_PC;
    end else begin
      if (ms) begin nv[4] = 0; nc[4] = 0; end
      else begin nv[4] = mv[3]; nc[4] = ec[3]; npc[4] = mpc[3]; end
      if (!ms) begin nv[3] = mv[2]; nc[3] = ec[2]; npc[3] = mpc[2]; end
      if (!ms) begin
        if (ids) begin nv[2] = 0; nc[2] = 0; end
        else begin nv[2] = mv[1]; nc[2] = ec[1]; npc[2] = mpc[1]; end
      end
      if (!stl) begin
        nv[1] = mv[0]; nc[1] = ec[0]; npc[1] = mpc[0];
        nv[0] = fv; nc[0] = 0; npc[0] = mfpc;
        if (fv) mfpc = mfpc + 4;
      end
    end
    for (int k = 0; k < 5; k++) begin
      mv[k] = nv[k]; mc[k] = (nv[k] != 0) ? nc[k] : 0; mpc[k] = npc[k];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1, 0, 0, 3'b000, 0, 0, 3'b000);
  endtask

  task automatic wait_trap(input logic [31:0] ep, input int ecause, input string tag);
    bit got = 0;
    for (int i = 0; i < 10; i++) begin
      idle();
      if (trap) begin
        chk("R9 flush all", {28'b0, flush}, 32'hF);
        chk("R8 no write on fault", {31'b0, rf_we}, 32'h0);
        got = 1;
        tick();
        break;
      end
      tick();
    end
    chk({tag, " trap seen"}, {31'b0, got}, 32'h1);
    chk({tag, " trap_pc"}, trap_pc, ep);
    chk({tag, " trap_cause"}, {29'b0, trap_cause}, ecause);
  endtask

  // refill after a trap; noisy strobes hit an empty pipeline (R13)
  task automatic refill(input bit noisy);
    for (int i = 0; i < 6; i++) begin
      if (noisy && i == 0) drive(1, 0, 0, 3'b111, 1, 1, 3'b111);
      else idle();
      if (i == 0) chk("R10 redirect", fetch_pc, HND_PC);
      if (i < 5) chk("R9 no retire after flush", {31'b0, rf_we}, 32'h0);
      if (noisy && i > 0) chk("R13 empty-stage strobe ignored", {31'b0, trap}, 32'h0);
      if (i == 5) begin
        chk("R10 handler retires", {31'b0, rf_we}, 32'h1);
        chk("R10 handler pc", retire_pc, HND_PC);
      end
      tick();
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] p;
    model_reset();
    repeat (3) @(negedge clk);
    // R1
    chk("R1 trap", {31'b0, trap}, 32'h0);
    chk("R1 rf_we", {31'b0, rf_we}, 32'h0);
    chk("R1 mem_acc", {31'b0, mem_acc}, 32'h0);
    chk("R1 fetch_pc", fetch_pc, RST_PC);
    chk("R1 trap_pc", trap_pc, 32'h0);
    chk("R1 trap_cause", {29'b0, trap_cause}, 32'h0);
    rst_ni = 1'b1;

    // R2: plain stream
    for (int i = 0; i < 6; i++) begin
      idle();
      if (i == 5) begin
        chk("R2 first retire", {31'b0, rf_we}, 32'h1);
        chk("R2 first pc", retire_pc, RST_PC);
      end
      tick();
    end

    // R3: fetch causes and their priority
    p = fetch_pc; drive(1, 0, 0, 3'b111, 0, 0, 3'b000); tick(); wait_trap(p - 4, 1, "R3 page"); refill(0);
    p = fetch_pc; drive(1, 0, 0, 3'b110, 0, 0, 3'b000); tick(); wait_trap(p - 4, 2, "R3 misaligned"); refill(0);
    p = fetch_pc; drive(1, 0, 0, 3'b100, 0, 0, 3'b000); tick(); wait_trap(p - 4, 3, "R3 protection"); refill(1);

    // R4: later-stage causes
    p = fetch_pc; drive(1, 0, 0, 3'b000, 1, 0, 3'b000); tick(); wait_trap(p - 8, 4, "R4 illegal"); refill(0);
    p = fetch_pc; drive(1, 0, 0, 3'b000, 0, 1, 3'b000); tick(); wait_trap(p - 12, 5, "R4 arith"); refill(0);
    p = fetch_pc; drive(1, 0, 0, 3'b000, 0, 0, 3'b011); tick(); wait_trap(p - 16, 6, "R4 data page"); refill(0);
    p = fetch_pc; drive(1, 0, 0, 3'b000, 0, 0, 3'b010); tick(); wait_trap(p - 16, 7, "R4 data misaligned"); refill(0);
    p = fetch_pc; drive(1, 0, 0, 3'b000, 0, 0, 3'b100); tick(); wait_trap(p - 16, 7, "R4 data protection"); refill(0);

    // R6: older wins, same cycle
    p = fetch_pc; drive(1, 0, 0, 3'b001, 1, 0, 3'b100); tick(); wait_trap(p - 16, 7, "R6 same cycle"); refill(0);
    // R6: younger flagged first, older flagged one cycle later
    p = fetch_pc;
    drive(1, 0, 0, 3'b001, 0, 0, 3'b000); tick();
    drive(1, 0, 0, 3'b000, 0, 1, 3'b000); tick();
    wait_trap(p - 8, 5, "R6 staggered"); refill(0);

    // R7 / R8: first cause sticks, no memory access for faulted instruction
    p = fetch_pc;
    drive(1, 0, 0, 3'b010, 0, 0, 3'b000); tick();
    drive(1, 0, 0, 3'b000, 1, 0, 3'b000); tick();
    drive(1, 0, 0, 3'b000, 0, 1, 3'b000); tick();
    drive(1, 0, 0, 3'b000, 0, 0, 3'b001);
    chk("R8 mem_acc off for faulted", {31'b0, mem_acc}, 32'h0);
    tick();
    wait_trap(p - 4, 2, "R7 sticky"); refill(0);

    // R11: decode stall, fault raised while held
    p = fetch_pc;
    drive(1, 1, 0, 3'b000, 0, 0, 3'b000); tick();
    drive(1, 1, 0, 3'b000, 1, 0, 3'b000);
    chk("R11 fetch held", fetch_pc, p);
    tick();
    drive(1, 1, 0, 3'b000, 0, 0, 3'b000); tick();
    drive(1, 0, 0, 3'b000, 0, 0, 3'b000);
    chk("R11 fetch still held", fetch_pc, p);
    tick();
    wait_trap(p - 8, 4, "R11 stall fault"); refill(0);

    // R12: memory stall, fault raised while held
    p = fetch_pc;
    drive(1, 0, 1, 3'b000, 0, 0, 3'b000); tick();
    drive(1, 0, 1, 3'b000, 0, 0, 3'b001);
    chk("R12 wb bubble", {31'b0, rf_we}, 32'h0);
    tick();
    drive(1, 0, 1, 3'b000, 0, 0, 3'b000);
    chk("R12 wb bubble again", {31'b0, rf_we}, 32'h0);
    chk("R12 fetch held", fetch_pc, p);
    tick();
    wait_trap(p - 16, 6, "R12 stall fault"); refill(1);

    for (int i = 0; i < 4; i++) begin idle(); tick(); end
    finish_run();
  end
endmodule